// File: doc/BRIEF.md
# Fault-Injectable Bit-Wide RAM

This block is a small synchronous single-bit-per-word RAM that can carry one functional defect at a time. It is meant to sit under a memory self-test sequencer as its device under test. A sequencer can then run its algorithms against both a clean array and an array with a known defect, and confirm that each defect class is flagged.

One access takes place per clock. An access is a read or a write of one cell. A read result appears on `rd_bit` one cycle after the request and holds until the next read.

A set of static configuration inputs picks the defect:
- the defect kind;
- the victim cell;
- the aggressor cell;
- a trigger polarity;
- a forced value.

The defects cover stuck cells, blocked transitions, coupling between two cells (inversion, idempotent and access-triggered), and AND/OR shorts between two cells. Reads never disturb the stored contents by themselves.

Top module: `flt_ram`

## Requirements
- R1: While reset is asserted and after it is released, every cell holds 0 and `rd_bit` is 0.
- R2: With `flt_kind` = 0, a write stores `wr_bit` at `addr`. A read (`acc_en`=1, `wr_en`=0) presents the cell value on `rd_bit` after the next rising edge. `rd_bit` keeps its value in cycles without a read.
- R3: A read changes no cell contents, except through the access-triggered coupling of kind 5.
- R4: Kind 1 (stuck): reading the victim returns `flt_val` whatever was written to it. The stored contents are kept and reappear once the kind returns to 0.
- R5: Kind 2 (transition): with `flt_val`=0 a write of 1 into a victim holding 0 leaves it at 0. With `flt_val`=1 a write of 0 into a victim holding 1 leaves it at 1. The opposite change works normally.
- R6: Kind 3 (inverting coupling): a write that changes the aggressor in the direction selected by `flt_trig` inverts the victim in the same cycle. `flt_trig`=1 selects a 0-to-1 change and `flt_trig`=0 selects a 1-to-0 change. A write that does not change the aggressor, or changes it the other way, leaves the victim alone.
- R7: Kind 4 (idempotent coupling): under the same trigger rule as R6, the victim is set to `flt_val`.
- R8: Kind 5 (access coupling): any read or write of the aggressor sets the victim to `flt_val` when the value involved equals `flt_trig`. For a write that value is the written bit; for a read it is the stored bit.
- R9: Kinds 6 and 7 (bridging): a read of either the victim or the aggressor returns the AND (kind 6) or the OR (kind 7) of the two stored bits. The stored bits themselves are unchanged.
- R10: Kind values 8 to 15 behave as kind 0. Coupling kinds have no effect when victim and aggressor are the same cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Access request this cycle |
| wr_en | input | 1 | 1 = write, 0 = read (when `acc_en`=1) |
| addr | input | AW | Cell address |
| wr_bit | input | 1 | Write data |
| rd_bit | output | 1 | Registered read data |
| flt_kind | input | 4 | Defect kind (0 none, 1 stuck, 2 transition, 3 inverting, 4 idempotent, 5 access, 6 AND short, 7 OR short) |
| flt_victim | input | AW | Victim cell address |
| flt_aggr | input | AW | Aggressor cell address |
| flt_trig | input | 1 | Trigger direction or trigger value for coupling kinds |
| flt_val | input | 1 | Forced value / blocked-direction select |

## Verification
On every cycle the assertions check the following:
- a clean write lands in its cell;
- `rd_bit` holds between reads;
- reads leave the array untouched outside kind 5;
- a stuck victim reads its forced value;
- a blocked up transition leaves the victim at 0;
- a matching aggressor change flips an inverting victim.

Some behaviours need ordered scenarios and are shown only by the bench:
- the stored contents surviving a stuck or bridged period;
- the trigger-direction selection of idempotent coupling;
- the read-triggered branch of access coupling;
- the handling of out-of-range kind codes.

// File: rtl/flt_ram_pkg.sv
package flt_ram_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    FK_NONE  = 4'd0,
    FK_STUCK = 4'd1,
    FK_TRANS = 4'd2,
    FK_CINV  = 4'd3,
    FK_CIDEM = 4'd4,
    FK_CDYN  = 4'd5,
    FK_BAND  = 4'd6,
    FK_BOR   = 4'd7
  } fk_e;

  // Unknown codes fall back to an ideal array (R10)
  function automatic fk_e fk_decode(input logic [KIND_W-1:0] code);
    fk_e k;
    case (code)
      4'd1: k = FK_STUCK;
      4'd2: k = FK_TRANS;
      4'd3: k = FK_CINV;
      4'd4: k = FK_CIDEM;
      4'd5: k = FK_CDYN;
      4'd6: k = FK_BAND;
      4'd7: k = FK_BOR;
      default: k = FK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/flt_ram_rst_sync.sv
module flt_ram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/flt_ram_update.sv
module flt_ram_update
  import flt_ram_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] mem_q,
  input  logic             acc_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic             wr_bit,
  input  fk_e              kind,
  input  logic [AW-1:0]    victim,
  input  logic [AW-1:0]    aggr,
  input  logic             trig,
  input  logic             fval,
  output logic [DEPTH-1:0] mem_d
);

  logic agg_cur, agg_hit, agg_rise, agg_fall, edge_hit, acc_val, dyn_hit, cpl_on;

  // Aggressor-side event detection, shared by all cells
  always_comb begin
    agg_cur  = mem_q[aggr];
    agg_hit  = acc_en && (addr == aggr);
    agg_rise = agg_hit && wr_en && !agg_cur && wr_bit;
    agg_fall = agg_hit && wr_en && agg_cur && !wr_bit;
    edge_hit = trig ? agg_rise : agg_fall;
    acc_val  = wr_en ? wr_bit : agg_cur;
    dyn_hit  = agg_hit && (acc_val == trig);
    cpl_on   = (victim != aggr);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic wr_hit, is_vic, blocked, nxt;

    always_comb begin
      wr_hit  = acc_en && wr_en && (addr == AW'(i));
      is_vic  = (victim == AW'(i));
      blocked = is_vic && (kind == FK_TRANS) &&
                (fval ? (mem_q[i] && !wr_bit) : (!mem_q[i] && wr_bit));
      nxt     = mem_q[i];
      if (wr_hit) begin
        if (!blocked) nxt = wr_bit;
      end else if (is_vic && cpl_on) begin
        case (kind)
          FK_CINV:  if (edge_hit) nxt = ~mem_q[i];
          FK_CIDEM: if (edge_hit) nxt = fval;
          FK_CDYN:  if (dyn_hit)  nxt = fval;
          default:  nxt = mem_q[i];
        endcase
      end
      mem_d[i] = nxt;
    end
  end

endmodule

// File: rtl/flt_ram_read.sv
module flt_ram_read
  import flt_ram_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] mem_q,
  input  logic [AW-1:0]    addr,
  input  fk_e              kind,
  input  logic [AW-1:0]    victim,
  input  logic [AW-1:0]    aggr,
  input  logic             fval,
  output logic             rd_val
);

  logic raw, mv, ma, on_vic, on_pair;

  always_comb begin
    raw     = mem_q[addr];
    mv      = mem_q[victim];
    ma      = mem_q[aggr];
    on_vic  = (addr == victim);
    on_pair = on_vic || (addr == aggr);
    case (kind)
      FK_STUCK: rd_val = on_vic  ? fval    : raw;
      FK_BAND:  rd_val = on_pair ? (mv & ma) : raw;
      FK_BOR:   rd_val = on_pair ? (mv | ma) : raw;
      default:  rd_val = raw;
    endcase
  end

endmodule

// File: rtl/flt_ram.sv
module flt_ram
  import flt_ram_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic              wr_bit,
  output logic              rd_bit,
  input  logic [KIND_W-1:0] flt_kind,
  input  logic [AW-1:0]     flt_victim,
  input  logic [AW-1:0]     flt_aggr,
  input  logic              flt_trig,
  input  logic              flt_val
);

  logic             srst_n;
  fk_e              kind;
  logic [DEPTH-1:0] mem_q, mem_d;
  logic             rd_q, rd_d, rd_val;
  logic             rd_req;

  assign kind   = fk_decode(flt_kind);
  assign rd_req = acc_en && !wr_en;

  flt_ram_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  flt_ram_update #(.DEPTH(DEPTH), .AW(AW)) u_upd (
    .mem_q(mem_q), .acc_en(acc_en), .wr_en(wr_en), .addr(addr),
    .wr_bit(wr_bit), .kind(kind), .victim(flt_victim), .aggr(flt_aggr),
    .trig(flt_trig), .fval(flt_val), .mem_d(mem_d)
  );

  flt_ram_read #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .mem_q(mem_q), .addr(addr), .kind(kind), .victim(flt_victim),
    .aggr(flt_aggr), .fval(flt_val), .rd_val(rd_val)
  );

  always_comb begin
    rd_d = rd_req ? rd_val : rd_q;
  end

  // Array register: enabled only on an access (R1 clear on reset)
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     mem_q <= '0;
    else if (acc_en) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rd_q <= 1'b0;
    else         rd_q <= rd_d;
  end

  assign rd_bit = rd_q;

  // R2
  wr_ideal_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_en && wr_en && kind == FK_NONE) |=> mem_q[$past(addr)] == $past(wr_bit));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_req |=> $stable(rd_bit));

  // R3
  rd_pure_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_req && kind != FK_CDYN) |=> $stable(mem_q));

  // R4
  stuck_rd_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_req && kind == FK_STUCK && addr == flt_victim) |=> rd_bit == $past(flt_val));

  // R5
  up_block_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_en && wr_en && kind == FK_TRANS && !flt_val && addr == flt_victim &&
     !mem_q[flt_victim]) |=> !mem_q[$past(flt_victim)]);

  // R6
  inv_flip_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_en && wr_en && kind == FK_CINV && flt_victim != flt_aggr &&
     addr == flt_aggr && mem_q[flt_aggr] != wr_bit && wr_bit == flt_trig)
    |=> mem_q[$past(flt_victim)] != $past(mem_q[flt_victim]));

endmodule

// File: tb/sim_flt_ram.sv
module sim_flt_ram;

  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_en = 1'b0, wr_en = 1'b0, wr_bit = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_bit;
  logic [3:0]    flt_kind = '0;
  logic [AW-1:0] flt_victim = '0, flt_aggr = '0;
  logic          flt_trig = 1'b0, flt_val = 1'b0;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  rd_cap = 1'b0;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  flt_ram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en), .addr(addr),
    .wr_bit(wr_bit), .rd_bit(rd_bit), .flt_kind(flt_kind),
    .flt_victim(flt_victim), .flt_aggr(flt_aggr), .flt_trig(flt_trig),
    .flt_val(flt_val)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Monitor: a read accepted at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_cap <= rst_n && acc_en && !wr_en;

  always @(negedge clk) begin
    if (rd_cap) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: actual unexpected read expected none");
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(rd_bit, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input int a, input bit d);
    @(negedge clk);
    acc_en = 1'b1; wr_en = 1'b1; addr = a[AW-1:0]; wr_bit = d;
    @(negedge clk);
    acc_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input bit e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    acc_en = 1'b1; wr_en = 1'b0; addr = a[AW-1:0];
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic cfg(input int k, input int v, input int g, input bit t, input bit f);
    @(negedge clk);
    flt_kind = k[3:0]; flt_victim = v[AW-1:0]; flt_aggr = g[AW-1:0];
    flt_trig = t; flt_val = f;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_bit, 1'b0, "R1 rd_bit in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rd_bit, 1'b0, "R1 rd_bit after reset");
    rd(5, 1'b0, "R1 cell 5 clear");

    // R2 ideal behaviour
    wr(3, 1'b1); wr(7, 1'b1);
    rd(3, 1'b1, "R2 read 3");
    rd(7, 1'b1, "R2 read 7");
    rd(4, 1'b0, "R2 read 4");
    wr(4, 1'b1); wr(4, 1'b0);
    rd(4, 1'b0, "R2 overwrite 4");
    rd(7, 1'b1, "R2 read 7 again");
    repeat (3) @(negedge clk);
    chk(rd_bit, 1'b1, "R2 hold between reads");

    // R3 reads are pure
    rd(3, 1'b1, "R3 read 3 a"); rd(3, 1'b1, "R3 read 3 b");
    rd(4, 1'b0, "R3 read 4 a"); rd(4, 1'b0, "R3 read 4 b");

    // R10 unknown kind acts as ideal
    cfg(9, 10, 11, 1'b1, 1'b1);
    wr(10, 1'b1); rd(10, 1'b1, "R10 kind 9 ideal");
    wr(11, 1'b1); rd(10, 1'b1, "R10 kind 9 no coupling");

    // R4 stuck-at
    cfg(1, 5, 0, 1'b0, 1'b1);
    rd(5, 1'b1, "R4 stuck1 read");
    wr(5, 1'b0); rd(5, 1'b1, "R4 stuck1 after write 0");
    cfg(1, 3, 0, 1'b0, 1'b0);
    rd(3, 1'b0, "R4 stuck0 read");
    cfg(0, 0, 0, 1'b0, 1'b0);
    rd(3, 1'b1, "R4 storage kept");

    // R5 transition faults
    cfg(2, 8, 0, 1'b0, 1'b0);
    wr(8, 1'b1); rd(8, 1'b0, "R5 up blocked");
    cfg(0, 0, 0, 1'b0, 1'b0);
    wr(8, 1'b1);
    cfg(2, 8, 0, 1'b0, 1'b1);
    wr(8, 1'b0); rd(8, 1'b1, "R5 down blocked");
    cfg(2, 8, 0, 1'b0, 1'b0);
    wr(8, 1'b0); rd(8, 1'b0, "R5 down allowed when up blocked");

    // R6 inverting coupling, victim 12, aggressor 13
    cfg(3, 12, 13, 1'b1, 1'b0);
    wr(13, 1'b1); rd(12, 1'b1, "R6 rise inverts");
    wr(13, 1'b1); rd(12, 1'b1, "R6 no change no effect");
    wr(13, 1'b0); rd(12, 1'b1, "R6 wrong direction no effect");
    cfg(3, 12, 13, 1'b0, 1'b0);
    wr(13, 1'b1); wr(13, 1'b0); rd(12, 1'b0, "R6 fall inverts");

    // R7 idempotent coupling, victim 14, aggressor 15
    cfg(4, 14, 15, 1'b1, 1'b1);
    wr(15, 1'b1); rd(14, 1'b1, "R7 rise sets 1");
    cfg(4, 14, 15, 1'b1, 1'b0);
    wr(15, 1'b0); rd(14, 1'b1, "R7 fall ignored");
    wr(15, 1'b1); rd(14, 1'b0, "R7 rise sets 0");

    // R8 access coupling, victim 20, aggressor 21
    cfg(5, 20, 21, 1'b1, 1'b1);
    rd(21, 1'b0, "R8 aggr read 0");
    rd(20, 1'b0, "R8 non-matching read no effect");
    wr(21, 1'b1); rd(20, 1'b1, "R8 write of 1 forces");
    cfg(5, 20, 21, 1'b1, 1'b0);
    rd(21, 1'b1, "R8 aggr read 1");
    rd(20, 1'b0, "R8 read of 1 forces");

    // R9 bridging between 24 and 25
    cfg(0, 0, 0, 1'b0, 1'b0);
    wr(24, 1'b1); wr(25, 1'b0);
    cfg(6, 24, 25, 1'b0, 1'b0);
    rd(24, 1'b0, "R9 AND victim"); rd(25, 1'b0, "R9 AND aggr");
    cfg(7, 24, 25, 1'b0, 1'b0);
    rd(24, 1'b1, "R9 OR victim"); rd(25, 1'b1, "R9 OR aggr");
    cfg(0, 0, 0, 1'b0, 1'b0);
    rd(24, 1'b1, "R9 storage 24"); rd(25, 1'b0, "R9 storage 25");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, 1'b1, "R2 all reads returned");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule